// File: doc/BRIEF.md
# Interrupt Controller with Acknowledge Sequencer

This block gathers twenty interrupt request lines, fifteen from external pins and five from on-chip sources, and arranges them into three banks of eight priority slots. Whenever a request that is unmasked and outranks everything currently in service is present, it raises one interrupt line toward the processor. The processor answers with two acknowledge bus cycles. The controller runs each of those cycles itself: it holds the cycle for a fixed count of wait clocks and then ends it with a one-clock ready strobe.

The first acknowledge cycle freezes the winning slot and marks it in service. During the second cycle the block drives an 8-bit vector on the data bus, built from a per-bank base and the slot's position within its bank. Any external input may be flagged as feeding a slave controller of eight inputs. For such an input the block publishes the input's code on a cascade-select output and leaves the data bus undriven, so that the slave can answer instead. Software programs the masks, the bank bases and the cascade flags through a small write port. The same port issues a non-specific end-of-interrupt command.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset all slots are masked, every in-service bit is clear, the vector bases and cascade flags are zero, and `int_o`, `ready_o`, `data_oe_o` and `cas_act_o` are low.
- R2: `int_o` is high exactly when some request is unmasked and has no in-service bit set at its own slot or at any higher-priority slot.
- R3: For every accepted acknowledge strobe, `ready_o` stays low for the five clocks that follow the strobe clock, goes high for exactly one clock, and then falls.
- R4: On the first acknowledge cycle the highest-priority eligible slot is frozen and its in-service bit is set. `data_oe_o` stays low for the whole of that cycle.
- R5: On the second acknowledge cycle of a slot that is not cascaded, `data_oe_o` is high and `data_o` equals {bank base (5 bits), slot index within the bank (3 bits)} while `ready_o` is high.
- R6: Priority is fixed, and a lower slot number wins. External input n occupies slot n (n = 0..14) and internal input m occupies slot 15+m. The bank is slot/8 and the index is slot mod 8.
- R7: An in-service slot blocks requests at its own slot and at every lower-priority slot. Requests at higher-priority slots still raise `int_o`.
- R8: A write to address 8 clears only the highest-priority in-service bit. The written data is ignored.
- R9: If the frozen slot is an external input with its cascade flag set, `cas_act_o` goes high with `cas_code_o` equal to that input number. Both hold from the clock after the first strobe until the second cycle's ready clock ends. `data_oe_o` stays low throughout.
- R10: A first acknowledge that finds no eligible request sets no in-service bit. Its second cycle returns the bank-0 vector with index 7.
- R11: Register map, with bytes written on `wr_data_i`. Addresses 0, 1 and 2 hold the masks of banks 0, 1 and 2, where bit i set masks index i. Addresses 3, 4 and 5 hold the bases of banks 0, 1 and 2, taken from data bits 7:3. Address 6 holds the cascade flags of external inputs 0..7 in bits 7:0. Address 7 holds the cascade flags of external inputs 8..14 in bits 6:0.
- R12: The frozen slot is kept across any number of idle clocks between the two acknowledge cycles, even if higher-priority requests arrive in that gap. A strobe that arrives while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_ext_i | input | 15 | External interrupt request levels |
| irq_int_i | input | 5 | Internal interrupt request levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| int_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | One-clock strobe that opens an acknowledge cycle |
| ready_o | output | 1 | One-clock strobe that ends an acknowledge cycle |
| data_o | output | 8 | Interrupt vector |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| cas_act_o | output | 1 | Cascade select valid |
| cas_code_o | output | 4 | External input number whose slave must answer |

## Verification
The hardest situation to reach from the ports is a pair of nested in-service slots followed by a single end-of-interrupt. The bench acknowledges a low-priority slot, raises a higher one and acknowledges it as well. It then issues one end-of-interrupt and observes through `int_o` that only the higher slot was released. A second hard case arises when a higher-priority request appears in the gap between the two acknowledge cycles while a stray strobe lands in the middle of a wait period. The bench builds this by pulsing the strobe mid-cycle and raising slot 0 during a long gap, then checks the ready timing and that the vector still names the slot that was frozen.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_EXT       = 15;
    localparam int N_INT       = 5;
    localparam int BANK_W      = 8;
    localparam int N_BANKS     = 3;
    localparam int N_SLOT      = N_BANKS * BANK_W;
    localparam int IDX_W       = $clog2(BANK_W);
    localparam int SLOT_W      = $clog2(N_SLOT);
    localparam int DATA_W      = 8;
    localparam int BASE_W      = DATA_W - IDX_W;
    localparam int EXT_W       = $clog2(N_EXT);
    localparam int ADDR_W      = 4;
    localparam int WAIT_STATES = 5;
    localparam int CNT_W       = $clog2(WAIT_STATES + 1);

    // register addresses
    localparam int ADDR_MASK0  = 0;
    localparam int ADDR_BASE0  = ADDR_MASK0 + N_BANKS;
    localparam int ADDR_CAS0   = ADDR_BASE0 + N_BANKS;
    localparam int ADDR_EOI    = ADDR_CAS0 + (N_EXT + DATA_W - 1) / DATA_W;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_WAIT  = 2'd1,
        ACK_READY = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
    } grant_t;

    typedef struct packed {
        logic              cascaded;
        logic [SLOT_W-1:0] slot;
    } frozen_t;

    // lowest set bit wins: it is the highest priority
    function automatic grant_t first_set(input logic [N_SLOT-1:0] v);
        grant_t r;
        r = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.slot  = SLOT_W'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [DATA_W-1:0]                 wr_data_i,
    output logic [N_BANKS-1:0][BANK_W-1:0]    mask_o,
    output logic [N_BANKS-1:0][BASE_W-1:0]    base_o,
    output logic [N_EXT-1:0]                  cascade_o,
    output logic                              eoi_o
);
    logic [N_BANKS-1:0][BANK_W-1:0] mask_q;
    logic [N_BANKS-1:0][BASE_W-1:0] base_q;
    logic [N_EXT-1:0]               cas_q;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK0 + b);
        localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(ADDR_BASE0 + b);
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[b] <= '1;
                base_q[b] <= '0;
            end else if (wr_en_i) begin
                if (wr_addr_i == A_MASK) mask_q[b] <= wr_data_i[BANK_W-1:0];
                if (wr_addr_i == A_BASE) base_q[b] <= wr_data_i[DATA_W-1:IDX_W];
            end
        end
    end

    for (genvar e = 0; e < N_EXT; e++) begin : g_cas
        localparam logic [ADDR_W-1:0] A_CAS = ADDR_W'(ADDR_CAS0 + e / DATA_W);
        localparam int                BIT   = e % DATA_W;
        always_ff @(posedge clk) begin
            if (rst)                               cas_q[e] <= 1'b0;
            else if (wr_en_i && wr_addr_i == A_CAS) cas_q[e] <= wr_data_i[BIT];
        end
    end

    assign mask_o    = mask_q;
    assign base_o    = base_q;
    assign cascade_o = cas_q;
    assign eoi_o     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_EOI));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SLOT-1:0] req_i,
    input  logic [N_SLOT-1:0] mask_i,
    input  logic              set_en_i,
    input  logic [SLOT_W-1:0] set_slot_i,
    input  logic              eoi_i,
    output grant_t            win_o
);
    logic [N_SLOT-1:0] isr_q, isr_d;
    logic [N_SLOT-1:0] pending, blocked, eligible;
    grant_t            top_isr;

    assign pending = req_i & ~mask_i;

    // blocked[i]: an in-service bit exists at slot i or above it in priority
    for (genvar i = 0; i < N_SLOT; i++) begin : g_block
        if (i == 0) begin : g_first
            assign blocked[i] = isr_q[i];
        end else begin : g_rest
            assign blocked[i] = blocked[i-1] | isr_q[i];
        end
    end

    assign eligible = pending & ~blocked;
    assign win_o    = first_set(eligible);
    assign top_isr  = first_set(isr_q);

    always_comb begin
        isr_d = isr_q;
        if (eoi_i && top_isr.valid) isr_d[top_isr.slot] = 1'b0;
        if (set_en_i)               isr_d[set_slot_i]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_d;
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           inta_i,
    input  grant_t                         win_i,
    input  logic [N_EXT-1:0]               cascade_i,
    input  logic [N_BANKS-1:0][BASE_W-1:0] base_i,
    output logic                           set_en_o,
    output logic [SLOT_W-1:0]              set_slot_o,
    output logic                           ready_o,
    output logic [DATA_W-1:0]              data_o,
    output logic                           data_oe_o,
    output logic                           cas_act_o,
    output logic [EXT_W-1:0]               cas_code_o
);
    localparam logic [SLOT_W-1:0] SPURIOUS_SLOT = SLOT_W'(BANK_W - 1);
    localparam logic [CNT_W-1:0]  LAST_WAIT     = CNT_W'(WAIT_STATES - 1);

    ack_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              second_q;
    frozen_t           frz_q;
    logic              cas_act_q;
    logic [EXT_W-1:0]  cas_code_q;
    logic              accept, freeze, win_cas;
    logic [SLOT_W-IDX_W-1:0] bank_sel;

    assign accept  = (state_q == ACK_IDLE) && inta_i;
    assign freeze  = accept && !second_q;
    assign win_cas = win_i.valid && (win_i.slot < SLOT_W'(N_EXT))
                     && cascade_i[win_i.slot[EXT_W-1:0]];

    assign set_en_o   = freeze && win_i.valid;
    assign set_slot_o = win_i.slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ACK_IDLE;
            cnt_q      <= '0;
            second_q   <= 1'b0;
            frz_q      <= '0;
            cas_act_q  <= 1'b0;
            cas_code_q <= '0;
        end else begin
            case (state_q)
                ACK_IDLE: begin
                    if (accept) begin
                        state_q <= ACK_WAIT;
                        cnt_q   <= '0;
                    end
                    if (freeze) begin
                        frz_q.slot     <= win_i.valid ? win_i.slot : SPURIOUS_SLOT;
                        frz_q.cascaded <= win_cas;
                        cas_act_q      <= win_cas;
                        cas_code_q     <= win_i.slot[EXT_W-1:0];
                    end
                end
                ACK_WAIT: begin
                    if (cnt_q == LAST_WAIT) state_q <= ACK_READY;
                    else                    cnt_q   <= cnt_q + 1'b1;
                end
                ACK_READY: begin
                    state_q  <= ACK_IDLE;
                    second_q <= !second_q;
                    if (second_q) cas_act_q <= 1'b0;
                end
                default: state_q <= ACK_IDLE;
            endcase
        end
    end

    assign bank_sel   = frz_q.slot[SLOT_W-1:IDX_W];
    assign ready_o    = (state_q == ACK_READY);
    assign data_oe_o  = second_q && (state_q != ACK_IDLE) && !frz_q.cascaded;
    assign data_o     = data_oe_o ? {base_i[bank_sel], frz_q.slot[IDX_W-1:0]} : '0;
    assign cas_act_o  = cas_act_q;
    assign cas_code_o = cas_act_q ? cas_code_q : '0;
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_EXT-1:0]  irq_ext_i,
    input  logic [N_INT-1:0]  irq_int_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              int_o,
    input  logic              inta_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              cas_act_o,
    output logic [EXT_W-1:0]  cas_code_o
);
    localparam int N_SPARE = N_SLOT - N_EXT - N_INT;

    logic [N_SLOT-1:0]              req;
    logic [N_BANKS-1:0][BANK_W-1:0] mask;
    logic [N_BANKS-1:0][BASE_W-1:0] base;
    logic [N_EXT-1:0]               cascade;
    logic                           eoi;
    grant_t                         win;
    logic                           set_en;
    logic [SLOT_W-1:0]              set_slot;

    if (N_SPARE > 0) begin : g_spare
        assign req = {{N_SPARE{1'b0}}, irq_int_i, irq_ext_i};
    end else begin : g_full
        assign req = {irq_int_i, irq_ext_i};
    end

    irq_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask),
        .base_o    (base),
        .cascade_o (cascade),
        .eoi_o     (eoi)
    );

    irq_resolver u_res (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .mask_i     (mask),
        .set_en_i   (set_en),
        .set_slot_i (set_slot),
        .eoi_i      (eoi),
        .win_o      (win)
    );

    irq_ack_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .inta_i     (inta_i),
        .win_i      (win),
        .cascade_i  (cascade),
        .base_i     (base),
        .set_en_o   (set_en),
        .set_slot_o (set_slot),
        .ready_o    (ready_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .cas_act_o  (cas_act_o),
        .cas_code_o (cas_code_o)
    );

    assign int_o = win.valid;
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [N_EXT-1:0]  irq_ext_i,
    input logic [N_INT-1:0]  irq_int_i,
    input logic              int_o,
    input logic              inta_i,
    input logic              ready_o,
    input logic              data_oe_o,
    input logic              cas_act_o,
    input logic [EXT_W-1:0]  cas_code_o
);
    // independent model of one acknowledge bus cycle
    logic       busy;
    logic [7:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (inta_i) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (cnt == 8'(WAIT_STATES)) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + 8'd1;
        end
    end

    AST_RDY_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o); // R3

    AST_RDY_AFTER_WAITS: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (busy && cnt == 8'(WAIT_STATES))); // R3

    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        int_o |-> ((|irq_ext_i) || (|irq_int_i))); // R2

    AST_OE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> busy); // R5

    AST_CAS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        cas_act_o |-> !data_oe_o); // R9

    AST_CAS_CODE_EXT: assert property (@(posedge clk) disable iff (rst)
        cas_act_o |-> (cas_code_o < EXT_W'(N_EXT))); // R9
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_ext_i  (irq_ext_i),
    .irq_int_i  (irq_int_i),
    .int_o      (int_o),
    .inta_i     (inta_i),
    .ready_o    (ready_o),
    .data_oe_o  (data_oe_o),
    .cas_act_o  (cas_act_o),
    .cas_code_o (cas_code_o)
);

// File: tb/sim_irq_ack_ctrl.sv
module sim_irq_ack_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] irq_ext;
    logic [4:0]  irq_int;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        int_o;
    logic        inta;
    logic        ready_o;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        cas_act_o;
    logic [3:0]  cas_code_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ack_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .irq_ext_i  (irq_ext),
        .irq_int_i  (irq_int),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .int_o      (int_o),
        .inta_i     (inta),
        .ready_o    (ready_o),
        .data_o     (data_o),
        .data_oe_o  (data_oe_o),
        .cas_act_o  (cas_act_o),
        .cas_code_o (cas_code_o)
    );

    typedef struct packed {
        logic [14:0] ext;
        logic [4:0]  intr;
        logic [7:0]  vec;
        logic        cas;
        logic [3:0]  code;
    } vec_t;

    // bases: bank0 0x40, bank1 0x80, bank2 0xC0; external 12 cascaded
    localparam vec_t TBL [8] = '{
        '{15'h0001, 5'h00, 8'h40, 1'b0, 4'd0},   // slot 0
        '{15'h0220, 5'h00, 8'h45, 1'b0, 4'd0},   // slots 5,9 -> 5
        '{15'h0200, 5'h00, 8'h81, 1'b0, 4'd0},   // slot 9
        '{15'h0000, 5'h01, 8'h87, 1'b0, 4'd0},   // internal 0 = slot 15
        '{15'h0000, 5'h10, 8'hC3, 1'b0, 4'd0},   // internal 4 = slot 19
        '{15'h0000, 5'h06, 8'hC0, 1'b0, 4'd0},   // internals 1,2 -> slot 16
        '{15'h1000, 5'h00, 8'h00, 1'b1, 4'd12},  // cascaded external 12
        '{15'h4000, 5'h08, 8'h86, 1'b0, 4'd0}    // slot 14 beats slot 18
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // one acknowledge bus cycle; returns values seen in the ready clock
    task automatic ack(output int waits, output logic [7:0] v, output logic oe,
                       output logic ca, output logic [3:0] cc, output logic oe_any);
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        waits = 0; oe_any = 1'b0;
        while (!ready_o && waits < 20) begin
            oe_any = oe_any | data_oe_o;
            waits++;
            @(negedge clk);
        end
        v = data_o; oe = data_oe_o; ca = cas_act_o; cc = cas_code_o;
        oe_any = oe_any | data_oe_o;
        @(negedge clk);
        chk(!ready_o, "R3 ready one clock", ready_o, 0);
    endtask

    task automatic full_ack(output logic [7:0] v, output logic oe,
                            output logic ca, output logic [3:0] cc);
        int w; logic [7:0] v1; logic oe1, ca1, oea; logic [3:0] cc1;
        ack(w, v1, oe1, ca1, cc1, oea);
        chk(w == 5, "R3 wait count first", w, 5);
        chk(!oea, "R4 bus idle first cycle", oea, 0);
        repeat (4) @(negedge clk);
        ack(w, v, oe, ca, cc, oea);
        chk(w == 5, "R3 wait count second", w, 5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v; logic oe, ca; logic [3:0] cc;
        int w;
        rst = 1'b1; irq_ext = '0; irq_int = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; inta = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!int_o && !ready_o && !data_oe_o && !cas_act_o, "R1 outputs idle",
            {int_o, ready_o, data_oe_o, cas_act_o}, 0);
        irq_ext = 15'h0001; #1;
        chk(!int_o, "R1 masked after reset", int_o, 0);

        // R10 spurious vector with everything masked
        full_ack(v, oe, ca, cc);
        chk(oe && v == 8'h07, "R10 spurious vector", v, 8'h07);
        irq_ext = '0;

        // R11 programming
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        wr(4'd3, 8'h40); wr(4'd4, 8'h80); wr(4'd5, 8'hC0);
        wr(4'd6, 8'h00); wr(4'd7, 8'h10);

        // table walk: R2 R5 R6 R9
        foreach (TBL[i]) begin
            @(negedge clk);
            irq_ext = TBL[i].ext; irq_int = TBL[i].intr; #1;
            chk(int_o, "R2 int raised", int_o, 1);
            full_ack(v, oe, ca, cc);
            if (TBL[i].cas) begin
                chk(!oe && ca && cc == TBL[i].code, "R9 cascade select",
                    {oe, ca, cc}, {1'b0, 1'b1, TBL[i].code});
                chk(!cas_act_o, "R9 cascade released", cas_act_o, 0);
            end else begin
                chk(oe && v == TBL[i].vec && !ca, "R6 R5 vector", v, TBL[i].vec);
            end
            irq_ext = '0; irq_int = '0;
            wr(4'd8, 8'hFF);
            #1;
            chk(!int_o, "R2 int low when idle", int_o, 0);
        end

        // R7 blocking by in-service slot 3
        irq_ext = 15'h0008;
        full_ack(v, oe, ca, cc);
        chk(v == 8'h43, "R7 slot 3 vector", v, 8'h43);
        #1; chk(!int_o, "R7 equal blocked", int_o, 0);
        irq_ext = 15'h0048; #1;
        chk(!int_o, "R7 lower blocked", int_o, 0);
        irq_ext = 15'h004A; #1;
        chk(int_o, "R7 higher passes", int_o, 1);

        // R8 nested: acknowledge slot 1 on top of slot 3
        full_ack(v, oe, ca, cc);
        chk(v == 8'h41, "R8 nested slot 1", v, 8'h41);
        wr(4'd8, 8'h00);
        #1; chk(int_o, "R8 slot 1 released", int_o, 1);
        irq_ext = 15'h0048; #1;
        chk(!int_o, "R8 slot 3 still in service", int_o, 0);
        wr(4'd8, 8'h00);
        #1; chk(int_o, "R8 slot 3 released", int_o, 1);
        irq_ext = '0;

        // R12 stray strobe and long gap with a new higher request
        irq_ext = 15'h0004;
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        @(negedge clk); inta = 1'b1;
        @(negedge clk); inta = 1'b0;
        w = 2;
        while (!ready_o && w < 20) begin w++; @(negedge clk); end
        chk(w == 5, "R12 stray strobe ignored", w, 5);
        @(negedge clk);
        irq_ext = 15'h0005;
        w = 0;
        repeat (8) begin @(negedge clk); if (ready_o) w++; end
        chk(w == 0, "R12 no extra cycle", w, 0);
        begin
            logic oea;
            ack(w, v, oe, ca, cc, oea);
        end
        chk(oe && v == 8'h42, "R12 frozen slot kept", v, 8'h42);
        irq_ext = '0;
        wr(4'd8, 8'h00);

        // R11 mask bit
        wr(4'd0, 8'h01);
        irq_ext = 15'h0001; #1;
        chk(!int_o, "R11 mask bit 0", int_o, 0);
        irq_ext = 15'h0002; #1;
        chk(int_o, "R11 unmasked bit 1", int_o, 1);
        irq_ext = '0;

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule